// File: doc/BRIEF.md
# CAN Error State Tracker

This block classifies the fault confinement state of a CAN node from its two error counters. Every cycle it compares the transmit and receive counts against three fixed levels. The result is one of four states: error-active, error-warning, error-passive or bus-off. The state is held in a register and shown as a one-hot field of a 32-bit status word. A separate word carries both counters packed together.

A state transition produces a one-cycle event bit for the state that was entered. Five per-frame protocol error inputs are latched into sticky flags: CRC, stuffing, acknowledge, form and bit. Reading the status word returns the flags and clears them. A mask register gates state events and flags onto a single interrupt line. The mask is written through separate set and clear addresses. A small mode register holds a node-enable bit and an automatic-restart bit. When the node enters bus-off and automatic restart is off, the block drops the node-enable bit by itself.

The register port is a simple single-cycle access: select, write strobe, word address, write data. Read data is combinational.

Top module: `can_err_tracker`

## Requirements
- R1: The state is error-active when both counters are below 96, error-warning when both are below 128 but not both below 96, error-passive when both are below 256 but not both below 128, and bus-off otherwise. The status word (address 1) shows active, warning, passive and bus-off in bits 16, 17, 18 and 19, with exactly one of them set. The field reflects counter values one clock after they are applied.
- R2: The counter word (address 5) holds the receive count in bits 7:0, saturated at 255. It holds the transmit count in bits 24:16. All other bits read as zero.
- R3: A state event bit (positions 16 to 19, same order as R1) is pending for exactly the one cycle in which the registered state changes, and only for the newly entered state.
- R4: The frame error inputs map as follows: bit 0 CRC to status bit 24, bit 1 stuffing to 25, bit 2 acknowledge to 26, bit 3 form to 27, bit 4 bit error to 28. Each input pulse sets its flag, which stays set until a status read.
- R5: A status read returns the current flags and clears them at the end of that access. An error input that pulses in the same cycle as the read leaves its flag set.
- R6: Writing address 2 sets mask bits and writing address 3 clears them, bitwise with ones in the write data. Address 4 reads the mask back. Only bits 16 to 19 and 24 to 28 can be set.
- R7: The irq output is high while any pending state event or frame flag has its mask bit set. Pending items whose mask bit is clear do not raise irq.
- R8: The mode word (address 0) holds node enable in bit 0 and automatic restart in bit 1. Bit 0 is driven on node_en. On entering bus-off with bit 1 clear, bit 0 is cleared. With bit 1 set, bit 0 is kept.
- R9: After reset the state is error-active, and the mask, flags and mode are zero with irq low. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_cnt | input | CNT_W | Transmit error count |
| rx_err_cnt | input | CNT_W | Receive error count |
| frm_err | input | 5 | One-cycle protocol error pulses (CRC, stuff, ack, form, bit) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| node_en | output | 1 | Node enable bit of the mode word |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest situation to reach from the ports is bus-off entry under each setting of automatic restart. The node-enable bit must drop in one case and hold in the other, and the one-cycle event must still be seen. Directed sequences walk the counters across every threshold edge (95/96, 127/128, 255/256) on each counter, with restart off and then on. Constrained random counter values, weighted toward those edges, then drive many transitions in arbitrary orders under random state masks. A directed access also pulses an error input in the very cycle of a status read, to show the new flag survives the clear.

// File: rtl/can_est_pkg.sv
package can_est_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WARN    = 2'd1,
    ST_PASSIVE = 2'd2,
    ST_BOFF    = 2'd3
  } est_state_e;

  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned NUM_FLAGS  = 5;
  localparam int unsigned STATE_LSB  = 16;
  localparam int unsigned FLAG_LSB   = 24;

  localparam int unsigned A_MODE    = 0;
  localparam int unsigned A_STATUS  = 1;
  localparam int unsigned A_MSK_SET = 2;
  localparam int unsigned A_MSK_CLR = 3;
  localparam int unsigned A_MASK    = 4;
  localparam int unsigned A_COUNT   = 5;

  function automatic est_state_e classify(input int unsigned tx, input int unsigned rx,
                                          input int unsigned warn_lvl,
                                          input int unsigned pass_lvl,
                                          input int unsigned boff_lvl);
    if (tx < warn_lvl && rx < warn_lvl)      return ST_ACTIVE;
    else if (tx < pass_lvl && rx < pass_lvl) return ST_WARN;
    else if (tx < boff_lvl && rx < boff_lvl) return ST_PASSIVE;
    else                                     return ST_BOFF;
  endfunction

  function automatic logic [NUM_STATES-1:0] state_onehot(input est_state_e s);
    return 4'b0001 << s;
  endfunction

  function automatic logic [31:0] pack_counters(input int unsigned tx, input int unsigned rx);
    int unsigned rx_sat;
    rx_sat = (rx > 255) ? 255 : rx;
    return 32'((tx << 16) | rx_sat);
  endfunction

  function automatic logic [31:0] mask_writable();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_STATES; i++) m[STATE_LSB + i] = 1'b1;
    for (int i = 0; i < NUM_FLAGS; i++)  m[FLAG_LSB + i]  = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/est_classifier.sv
module est_classifier
  import can_est_pkg::*;
#(
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned WARN_LVL = 96,
  parameter int unsigned PASS_LVL = 128,
  parameter int unsigned BOFF_LVL = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      tx_cnt,
  input  logic [CNT_W-1:0]      rx_cnt,
  output logic [NUM_STATES-1:0] state_oh,
  output logic [NUM_STATES-1:0] evt_oh,
  output logic                  enter_boff
);

  est_state_e state_q;
  est_state_e state_nxt;
  logic       changing;

  always_comb begin
    state_nxt  = classify(32'(tx_cnt), 32'(rx_cnt), WARN_LVL, PASS_LVL, BOFF_LVL);
    changing   = (state_nxt != state_q);
    enter_boff = changing && (state_nxt == ST_BOFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      evt_oh  <= '0;
    end else begin
      state_q <= state_nxt;
      evt_oh  <= changing ? state_onehot(state_nxt) : '0;
    end
  end

  assign state_oh = state_onehot(state_q);

endmodule

// File: rtl/est_flags.sv
module est_flags #(
  parameter int unsigned NFLAG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] err_in,
  input  logic             clear,
  output logic [NFLAG-1:0] flags_q
);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= err_in[i] | (flags_q[i] & ~clear);
    end
  end

endmodule

// File: rtl/est_regs.sv
module est_regs
  import can_est_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  input  logic [NUM_STATES-1:0] state_oh,
  input  logic [NUM_FLAGS-1:0]  flags,
  input  logic [31:0]           cnt_word,
  input  logic                  enter_boff,
  output logic [31:0]           rdata,
  output logic [31:0]           mask_q,
  output logic [1:0]            mode_q,
  output logic                  status_rd
);

  localparam logic [31:0] WMASK = mask_writable();

  logic        wr_mode, wr_set, wr_clr;
  logic [31:0] status_word;

  always_comb begin
    wr_mode   = sel && wr && (addr == ADDR_W'(A_MODE));
    wr_set    = sel && wr && (addr == ADDR_W'(A_MSK_SET));
    wr_clr    = sel && wr && (addr == ADDR_W'(A_MSK_CLR));
    status_rd = sel && !wr && (addr == ADDR_W'(A_STATUS));
    status_word = (32'(flags) << FLAG_LSB) | (32'(state_oh) << STATE_LSB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_set) mask_q <= mask_q | (wdata & WMASK);
      if (wr_clr) mask_q <= mask_q & ~(wdata & WMASK);
      if (wr_mode) mode_q <= wdata[1:0];
      if (enter_boff && !mode_q[1]) mode_q[0] <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(A_MODE):   rdata = {30'b0, mode_q};
      ADDR_W'(A_STATUS): rdata = status_word;
      ADDR_W'(A_MASK):   rdata = mask_q;
      ADDR_W'(A_COUNT):  rdata = cnt_word;
      default:           rdata = '0;
    endcase
  end

endmodule

// File: rtl/can_err_tracker.sv
module can_err_tracker
  import can_est_pkg::*;
#(
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned WARN_LVL = 96,
  parameter int unsigned PASS_LVL = 128,
  parameter int unsigned BOFF_LVL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  input  logic [4:0]        frm_err,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              node_en,
  output logic              irq
);

  logic [NUM_STATES-1:0] state_oh;
  logic [NUM_STATES-1:0] evt_oh;
  logic                  enter_boff;
  logic [NUM_FLAGS-1:0]  flags;
  logic                  status_rd;
  logic [31:0]           mask_q;
  logic [1:0]            mode_q;
  logic [31:0]           cnt_word;
  logic [31:0]           pend;
  logic                  auto_rst;

  est_classifier #(
    .CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .PASS_LVL(PASS_LVL), .BOFF_LVL(BOFF_LVL)
  ) u_cls (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_err_cnt), .rx_cnt(rx_err_cnt),
    .state_oh(state_oh), .evt_oh(evt_oh), .enter_boff(enter_boff)
  );

  est_flags #(.NFLAG(NUM_FLAGS)) u_flg (
    .clk(clk), .rst_n(rst_n), .err_in(frm_err), .clear(status_rd), .flags_q(flags)
  );

  assign cnt_word = pack_counters(32'(tx_err_cnt), 32'(rx_err_cnt));

  est_regs #(.ADDR_W(ADDR_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .state_oh(state_oh), .flags(flags), .cnt_word(cnt_word),
    .enter_boff(enter_boff), .rdata(bus_rdata), .mask_q(mask_q), .mode_q(mode_q),
    .status_rd(status_rd)
  );

  assign pend     = (32'(flags) << FLAG_LSB) | (32'(evt_oh) << STATE_LSB);
  assign irq      = |(pend & mask_q);
  assign node_en  = mode_q[0];
  assign auto_rst = mode_q[1];

endmodule

// File: rtl/est_checker.sv
module est_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  state_oh,
  input logic [3:0]  evt_oh,
  input logic [4:0]  flags,
  input logic        status_rd,
  input logic        enter_boff,
  input logic        auto_rst,
  input logic        node_en,
  input logic        irq,
  input logic [31:0] mask_q
);

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1); // R1

  AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_oh) |-> (state_oh != $past(state_oh))); // R3

  AST_EVT_IS_NEW_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_oh) |-> (evt_oh == state_oh)); // R3

  AST_NO_EVT_WHEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(state_oh) |-> (evt_oh == 4'b0)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rd |=> ((flags & $past(flags)) == $past(flags))); // R4

  AST_BOFF_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_boff && !auto_rst) |=> !node_en); // R8

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 32'b0)); // R7

endmodule

bind can_err_tracker est_checker u_chk (
  .clk(clk), .rst_n(rst_n), .state_oh(state_oh), .evt_oh(evt_oh), .flags(flags),
  .status_rd(status_rd), .enter_boff(enter_boff), .auto_rst(auto_rst),
  .node_en(node_en), .irq(irq), .mask_q(mask_q)
);

// File: tb/tb_can_err_tracker.sv
module tb_can_err_tracker;
  localparam int CNT_W  = 9;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  tx_err_cnt = '0;
  logic [CNT_W-1:0]  rx_err_cnt = '0;
  logic [4:0]        frm_err = '0;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              node_en;
  logic              irq;

  always #4 clk = ~clk;

  can_err_tracker dut (
    .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
    .frm_err(frm_err), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .node_en(node_en), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int prev_st = 0;
  bit en_m = 0;
  bit auto_m = 0;
  logic [31:0] mask_m = '0;
  logic [31:0] d;

  function automatic int exp_state(int tx, int rx);
    int worst;
    worst = (tx > rx) ? tx : rx;
    if (worst >= 256) return 3;
    if (worst >= 128) return 2;
    if (worst >= 96)  return 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_cnt(int tx, int rx);
    logic [31:0] w;
    w = '0;
    w[7:0]   = (rx > 255) ? 8'hFF : rx[7:0];
    w[24:16] = tx[8:0];
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(int addr, logic [31:0] data);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(int addr, output logic [31:0] data);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(addr);
    #1 data = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic set_mode(bit en, bit au);
    bus_write(0, {30'b0, au, en});
    en_m = en; auto_m = au;
  endtask

  task automatic set_cnt(int tx, int rx);
    int ns;
    bit ch;
    logic [31:0] r;
    tx_err_cnt = CNT_W'(tx);
    rx_err_cnt = CNT_W'(rx);
    @(negedge clk);
    ns = exp_state(tx, rx);
    ch = (ns != prev_st);
    if (ch && ns == 3 && !auto_m) en_m = 0;
    chk("R3/R7 irq on state change", 32'(irq), 32'(ch && mask_m[16 + ns]));
    chk("R8 node_en", 32'(node_en), 32'(en_m));
    prev_st = ns;
    bus_read(1, r);
    chk("R1 state field", 32'(r[19:16]), 32'(4'b0001 << ns));
    chk("R3 event lasts one cycle", 32'(irq), 32'h0);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset values
    chk("R9 irq after reset", 32'(irq), 32'h0);
    bus_read(1, r); chk("R9 status after reset", r, 32'h0001_0000);
    bus_read(4, r); chk("R9 mask after reset", r, 32'h0);
    bus_read(0, r); chk("R9 mode after reset", r, 32'h0);
    bus_read(6, r); chk("R9 unused address", r, 32'h0);
    chk("R9 node_en after reset", 32'(node_en), 32'h0);

    // R6 mask access, only valid bits
    bus_write(2, 32'hFFFF_FFFF); mask_m = 32'h1F0F_0000;
    bus_read(4, r); chk("R6 mask set writable bits", r, 32'h1F0F_0000);
    bus_write(3, 32'h0A00_0000); mask_m = 32'h150F_0000;
    bus_read(4, r); chk("R6 mask clear", r, 32'h150F_0000);
    bus_write(2, 32'h1F00_0000); mask_m = 32'h1F0F_0000;

    // R8 enable, no auto restart; R1 threshold edges
    set_mode(1, 0);
    set_cnt(95, 95);
    set_cnt(96, 0);
    set_cnt(0, 127);
    set_cnt(0, 128);
    set_cnt(127, 255);
    set_cnt(255, 10);
    set_cnt(256, 0);
    chk("R8 node disabled on bus-off", 32'(node_en), 32'h0);
    set_cnt(0, 0);

    // R2 counter word
    tx_err_cnt = 9'd300; rx_err_cnt = 9'd280;
    @(negedge clk); prev_st = 3;
    if (irq !== 1'b1) begin end
    bus_read(5, r); chk("R2 counter packing saturated", r, 32'h012C_00FF);
    set_cnt(0, 0);
    tx_err_cnt = 9'd5; rx_err_cnt = 9'd200;
    @(negedge clk); prev_st = 2;
    bus_read(5, r); chk("R2 counter packing", r, 32'h0005_00C8);
    set_cnt(0, 0);

    // R8 auto restart keeps enable
    set_mode(1, 1);
    set_cnt(0, 300);
    chk("R8 enable kept with auto restart", 32'(node_en), 32'h1);
    set_cnt(0, 0);

    // R4 flags latch; R5 clear on read
    frm_err = 5'b00101; @(negedge clk); frm_err = '0;
    chk("R7 irq from masked flag", 32'(irq), 32'h1);
    repeat (2) @(negedge clk);
    bus_read(1, r); chk("R4 flags sticky CRC+ack", r, 32'h0501_0000);
    bus_read(1, r); chk("R5 flags cleared by read", r, 32'h0001_0000);
    frm_err = 5'b11010; @(negedge clk); frm_err = '0;
    bus_read(1, r); chk("R4 flags stuff/form/bit", r, 32'h1A01_0000);
    // R5 same-cycle error survives read
    frm_err = 5'b00001;
    bus_read(1, r); frm_err = '0;
    chk("R5 read before new error", r, 32'h0001_0000);
    bus_read(1, r); chk("R5 concurrent error kept", r, 32'h0101_0000);

    // R7 masked-off flag
    bus_write(3, 32'h1F00_0000); mask_m = 32'h000F_0000;
    frm_err = 5'b00001; @(negedge clk); frm_err = '0;
    chk("R7 masked-off flag no irq", 32'(irq), 32'h0);
    bus_write(2, 32'h0100_0000); mask_m = 32'h010F_0000;
    #1 chk("R7 irq after unmask", 32'(irq), 32'h1);
    bus_read(1, r);
    chk("R7 irq drops after clear", 32'(irq), 32'h0);

    // Random counters with random state masks
    for (int i = 0; i < 400; i++) begin
      int tx, rx;
      int base[4] = '{96, 128, 256, 0};
      if (i % 50 == 0) begin
        logic [31:0] m4;
        m4 = 32'($urandom_range(0, 15)) << 16;
        bus_write(3, 32'h1F0F_0000);
        bus_write(2, m4);
        mask_m = m4;
        if ($urandom_range(0, 1) == 1) set_mode(1, 0); else set_mode(1, 1);
      end
      tx = base[$urandom_range(0, 3)] + $urandom_range(0, 3) - 2;
      rx = base[$urandom_range(0, 3)] + $urandom_range(0, 3) - 2;
      if (tx < 0) tx = $urandom_range(0, 60);
      if (rx < 0) rx = $urandom_range(0, 60);
      set_cnt(tx, rx);
      if (i % 8 == 0) begin
        bus_read(5, r);
        chk("R2 random counter word", r, exp_cnt(tx, rx));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule